// File: doc/BRIEF.md
# Real-Mode Interrupt Entry and Return Sequencer

This block steps a 16-bit real-address-mode core through entering an interrupt handler and coming back from one. When an interrupt request arrives with an 8-bit vector, the sequencer does the following:

- It captures the core's current code segment, instruction pointer, flags, stack segment and stack pointer.
- It pushes flags, then code segment, then instruction pointer onto a stack that grows downward.
- It clears the interrupt-enable and single-step flags.
- It reads the handler's far pointer from a vector table. The table starts at an address held in a table-base register, and each vector has a 4-byte slot in it.

A return command takes the three words back off the stack in the opposite order.

All stack writes and table reads go through one 16-bit memory port. Each access uses a request/acknowledge handshake. Stack addresses are formed as segment times sixteen plus offset. The resulting CS, IP, FLAGS and SP are presented on output ports. A one-cycle done pulse marks the point at which they are valid. A request that arrives while a sequence is running is kept and is started as soon as the sequencer is idle again.

Top module: `rm_int_seq`

## Requirements
- R1: After reset, busy, done and the memory request are low, and the CS, IP, FLAGS and SP outputs are all zero.
- R2: On an interrupt, three words are written at linear address (SS×16 + offset), where the offsets are SP−2, SP−4 and SP−6. The words are FLAGS, CS and IP, written in that order. The final SP is the entry SP minus 6, so IP sits at SS:SP, CS at SS:SP+2 and FLAGS at SS:SP+4.
- R3: The FLAGS word is pushed with its value at entry. The FLAGS output then has bit 9 (interrupt enable) and bit 8 (single step) cleared, and all other bits unchanged.
- R4: After the three pushes, IP is read from table base + vector×4 and then CS from table base + vector×4 + 2. These become the CS and IP outputs.
- R5: The table-base register is zero after reset. A write strobe loads it, and the new value is used by every later table read.
- R6: A return command reads IP at SS:SP, then CS at SS:SP+2, then FLAGS at SS:SP+4. It drives these values on the outputs and leaves SP increased by 6.
- R7: A memory request stays asserted, with address, direction and write data unchanged, until acknowledged. Each access is made exactly once, however long the acknowledge takes.
- R8: Done pulses for exactly one cycle when the new CS:IP is valid. Busy is high while the sequence is in progress and low in the cycle where done is high.
- R9: An interrupt request that arrives while busy is held, together with its vector. It starts after the running sequence ends. If an interrupt and a return are both waiting, the interrupt is served first.
- R10: Stack pointer arithmetic wraps modulo 2^16. For example, an entry SP of 0 pushes at offsets FFFE, FFFC and FFFA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | VEC_W | Vector accompanying irq_req |
| iret_req | input | 1 | Return-from-interrupt strobe |
| tbase_we | input | 1 | Table-base register write strobe |
| tbase_wdata | input | ADDR_W | New table-base value |
| cur_cs | input | WORD_W | Code segment, sampled when a sequence starts |
| cur_ip | input | WORD_W | Instruction pointer, sampled at start |
| cur_flags | input | WORD_W | Flags, sampled at start |
| cur_ss | input | WORD_W | Stack segment, sampled at start |
| cur_sp | input | WORD_W | Stack pointer, sampled at start |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Linear byte address of the word |
| mem_wdata | output | WORD_W | Write data |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | WORD_W | Read data, valid with mem_ack |
| new_cs | output | WORD_W | Resulting code segment |
| new_ip | output | WORD_W | Resulting instruction pointer |
| new_flags | output | WORD_W | Resulting flags |
| new_sp | output | WORD_W | Resulting stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a second interrupt that lands in the middle of a running sequence. To reach it, the bench stretches every acknowledge by two cycles. It then strobes a new vector while the first entry is still pushing, and changes irq_vec straight afterwards. This shows whether the held vector, and not the live input, selects the second table slot. A second hard case is stack wrap. An entry with SP equal to zero, followed by a return from that frame, drives the pointer across the 16-bit boundary in both directions.

// File: rtl/rm_int_pkg.sv
package rm_int_pkg;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_PUSH_FL = 4'd1,
        S_PUSH_CS = 4'd2,
        S_PUSH_IP = 4'd3,
        S_RD_IP   = 4'd4,
        S_RD_CS   = 4'd5,
        S_POP_IP  = 4'd6,
        S_POP_CS  = 4'd7,
        S_POP_FL  = 4'd8
    } seq_st_e;

    localparam int FL_TF_BIT = 8;
    localparam int FL_IF_BIT = 9;
    localparam int SEG_SHIFT = 4;

endpackage

// File: rtl/rm_int_addr.sv
module rm_int_addr #(
    parameter int ADDR_W = 20,
    parameter int VEC_W  = 8,
    parameter int WORD_W = 16
) (
    input  logic              use_tbl,
    input  logic              hi_word,
    input  logic [WORD_W-1:0] seg,
    input  logic [WORD_W-1:0] off,
    input  logic [ADDR_W-1:0] tbase,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr
);
    import rm_int_pkg::*;

    localparam int LIN_W = WORD_W + SEG_SHIFT;
    localparam int SUM_W = ((ADDR_W > LIN_W) ? ADDR_W : LIN_W) + 1;
    localparam int ENT_W = VEC_W + 2;

    logic [SUM_W-1:0]  stk_lin;
    logic [ENT_W-1:0]  ent_off;
    logic [ADDR_W-1:0] tbl_lin;

    always_comb begin
        stk_lin = SUM_W'({seg, {SEG_SHIFT{1'b0}}}) + SUM_W'(off);
        ent_off = {vec, hi_word, 1'b0};
        tbl_lin = tbase + ADDR_W'(ent_off);
        addr    = use_tbl ? tbl_lin : stk_lin[ADDR_W-1:0];
    end

endmodule

// File: rtl/rm_int_pend.sv
module rm_int_pend #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             iret_req,
    input  logic             take_irq,
    input  logic             take_iret,
    output logic             pend_irq,
    output logic [VEC_W-1:0] pend_vec,
    output logic             pend_iret
);

    typedef struct packed {
        logic             irq;
        logic [VEC_W-1:0] vec;
        logic             iret;
    } pend_t;

    pend_t pd_d, pd_q;

    always_comb begin
        pd_d = pd_q;
        if (take_irq) begin
            pd_d.irq = 1'b0;
        end else if (irq_req && !pd_q.irq) begin
            pd_d.irq = 1'b1;
            pd_d.vec = irq_vec;
        end
        if (take_iret) begin
            pd_d.iret = 1'b0;
        end else if (iret_req) begin
            pd_d.iret = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end

    assign pend_irq  = pd_q.irq;
    assign pend_vec  = pd_q.vec;
    assign pend_iret = pd_q.iret;

endmodule

// File: rtl/rm_int_seq.sv
module rm_int_seq #(
    parameter int ADDR_W = 20,
    parameter int VEC_W  = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              iret_req,
    input  logic              tbase_we,
    input  logic [ADDR_W-1:0] tbase_wdata,
    input  logic [WORD_W-1:0] cur_cs,
    input  logic [WORD_W-1:0] cur_ip,
    input  logic [WORD_W-1:0] cur_flags,
    input  logic [WORD_W-1:0] cur_ss,
    input  logic [WORD_W-1:0] cur_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_flags,
    output logic [WORD_W-1:0] new_sp,
    output logic              busy,
    output logic              done
);
    import rm_int_pkg::*;

    localparam logic [WORD_W-1:0] STEP     = WORD_W'(WORD_W / 8);
    localparam logic [WORD_W-1:0] CLR_MASK =
        ~((WORD_W'(1) << FL_IF_BIT) | (WORD_W'(1) << FL_TF_BIT));

    typedef struct packed {
        seq_st_e           state;
        logic [WORD_W-1:0] cs;
        logic [WORD_W-1:0] ip;
        logic [WORD_W-1:0] fl;
        logic [WORD_W-1:0] ss;
        logic [WORD_W-1:0] sp;
        logic [VEC_W-1:0]  vec;
        logic [ADDR_W-1:0] tbase;
        logic              done;
    } seq_regs_t;

    seq_regs_t st_d, st_q;

    logic              take_irq;
    logic              take_iret;
    logic              pend_irq;
    logic              pend_iret;
    logic [VEC_W-1:0]  pend_vec;
    logic              tbl_sel;
    logic              hi_sel;
    logic [WORD_W-1:0] stk_off;
    logic              idle;

    rm_int_pend #(.VEC_W(VEC_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .iret_req  (iret_req),
        .take_irq  (take_irq),
        .take_iret (take_iret),
        .pend_irq  (pend_irq),
        .pend_vec  (pend_vec),
        .pend_iret (pend_iret)
    );

    rm_int_addr #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .WORD_W(WORD_W)) u_addr (
        .use_tbl (tbl_sel),
        .hi_word (hi_sel),
        .seg     (st_q.ss),
        .off     (stk_off),
        .tbase   (st_q.tbase),
        .vec     (st_q.vec),
        .addr    (mem_addr)
    );

    always_comb begin
        idle      = (st_q.state == S_IDLE);
        take_irq  = idle && (pend_irq || irq_req);
        take_iret = idle && !take_irq && (pend_iret || iret_req);
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        tbl_sel   = 1'b0;
        hi_sel    = 1'b0;
        stk_off   = st_q.sp;

        if (tbase_we) st_d.tbase = tbase_wdata;

        unique case (st_q.state)
            S_IDLE: begin
                if (take_irq || take_iret) begin
                    st_d.cs = cur_cs;
                    st_d.ip = cur_ip;
                    st_d.fl = cur_flags;
                    st_d.ss = cur_ss;
                    st_d.sp = cur_sp;
                end
                if (take_irq) begin
                    st_d.vec   = pend_irq ? pend_vec : irq_vec;
                    st_d.state = S_PUSH_FL;
                end else if (take_iret) begin
                    st_d.state = S_POP_IP;
                end
            end
            S_PUSH_FL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = st_q.fl;
                stk_off   = st_q.sp - STEP;
                if (mem_ack) begin
                    st_d.sp    = st_q.sp - STEP;
                    st_d.fl    = st_q.fl & CLR_MASK;
                    st_d.state = S_PUSH_CS;
                end
            end
            S_PUSH_CS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = st_q.cs;
                stk_off   = st_q.sp - STEP;
                if (mem_ack) begin
                    st_d.sp    = st_q.sp - STEP;
                    st_d.state = S_PUSH_IP;
                end
            end
            S_PUSH_IP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = st_q.ip;
                stk_off   = st_q.sp - STEP;
                if (mem_ack) begin
                    st_d.sp    = st_q.sp - STEP;
                    st_d.state = S_RD_IP;
                end
            end
            S_RD_IP: begin
                mem_req = 1'b1;
                tbl_sel = 1'b1;
                if (mem_ack) begin
                    st_d.ip    = mem_rdata;
                    st_d.state = S_RD_CS;
                end
            end
            S_RD_CS: begin
                mem_req = 1'b1;
                tbl_sel = 1'b1;
                hi_sel  = 1'b1;
                if (mem_ack) begin
                    st_d.cs    = mem_rdata;
                    st_d.done  = 1'b1;
                    st_d.state = S_IDLE;
                end
            end
            S_POP_IP: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    st_d.ip    = mem_rdata;
                    st_d.sp    = st_q.sp + STEP;
                    st_d.state = S_POP_CS;
                end
            end
            S_POP_CS: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    st_d.cs    = mem_rdata;
                    st_d.sp    = st_q.sp + STEP;
                    st_d.state = S_POP_FL;
                end
            end
            S_POP_FL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    st_d.fl    = mem_rdata;
                    st_d.sp    = st_q.sp + STEP;
                    st_d.done  = 1'b1;
                    st_d.state = S_IDLE;
                end
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign new_cs    = st_q.cs;
    assign new_ip    = st_q.ip;
    assign new_flags = st_q.fl;
    assign new_sp    = st_q.sp;
    assign busy      = !idle;
    assign done      = st_q.done;

endmodule

// File: rtl/rm_int_chk.sv
module rm_int_chk #(
    parameter int ADDR_W = 20,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] new_sp,
    input logic [WORD_W-1:0] new_flags,
    input logic              tbl_sel,
    input logic              busy,
    input logic              done
);

    // R7: an unanswered request holds its address, direction and data
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2: each accepted push lowers SP by one word
    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_we) |=> (new_sp == $past(new_sp) - WORD_W'(2)));

    // R6: each accepted stack read raises SP by one word
    p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && !tbl_sel) |=> (new_sp == $past(new_sp) + WORD_W'(2)));

    // R3: interrupt enable and single step are already clear when the table is read
    p_flags_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && tbl_sel) |-> (new_flags[9:8] == 2'b00));

    // R4: table accesses are reads only
    p_tbl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && tbl_sel) |-> !mem_we);

    // R8: done lasts one cycle and is never seen while busy
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

bind rm_int_seq rm_int_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .new_sp    (new_sp),
    .new_flags (new_flags),
    .tbl_sel   (tbl_sel),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_rm_int_seq.sv
`timescale 1ns/1ps
module sim_rm_int_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic        iret_req = 1'b0;
    logic        tbase_we = 1'b0;
    logic [19:0] tbase_wdata = '0;
    logic [15:0] cur_cs = '0, cur_ip = '0, cur_flags = '0, cur_ss = '0, cur_sp = '0;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] new_cs, new_ip, new_flags, new_sp;
    logic        busy, done;

    int n_cmp = 0;
    int n_bad = 0;
    int ack_delay = 0;
    int wcnt = 0;
    int n_log = 0;
    int req_cycles = 0;
    logic [19:0] lg_addr [32];
    logic        lg_we   [32];
    logic [15:0] lg_data [32];
    logic [15:0] mem [int unsigned];

    always #4 clk = ~clk;

    rm_int_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
        .iret_req(iret_req), .tbase_we(tbase_we), .tbase_wdata(tbase_wdata),
        .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_flags(cur_flags),
        .cur_ss(cur_ss), .cur_sp(cur_sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .new_cs(new_cs), .new_ip(new_ip), .new_flags(new_flags),
        .new_sp(new_sp), .busy(busy), .done(done)
    );

    // memory model with programmable acknowledge latency
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= ack_delay) begin
                mem_ack = 1'b1;
                wcnt = 0;
                if (mem_we) begin
                    mem[int'(mem_addr)] = mem_wdata;
                end else begin
                    mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
                end
                lg_addr[n_log % 32] = mem_addr;
                lg_we[n_log % 32]   = mem_we;
                lg_data[n_log % 32] = mem_we ? mem_wdata : mem_rdata;
                n_log++;
            end else begin
                mem_ack = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ack = 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_log(input string tag, input int idx, input logic [19:0] a,
                           input logic w, input logic [15:0] dat);
        chk({tag, " addr"}, 32'(lg_addr[idx]), 32'(a));
        chk({tag, " dir"},  32'(lg_we[idx]),   32'(w));
        chk({tag, " data"}, 32'(lg_data[idx]), 32'(dat));
    endtask

    task automatic set_core(input logic [15:0] cs, ip, fl, ss, sp);
        cur_cs = cs; cur_ip = ip; cur_flags = fl; cur_ss = ss; cur_sp = sp;
    endtask

    task automatic fire_irq(input logic [7:0] v);
        @(negedge clk);
        irq_req = 1'b1; irq_vec = v;
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic fire_iret();
        @(negedge clk);
        iret_req = 1'b1;
        @(negedge clk);
        iret_req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int k = 0;
        req_cycles = 0;
        while (done !== 1'b1 && k < 400) begin
            if (mem_req === 1'b1) req_cycles++;
            @(negedge clk);
            k++;
        end
        chk({tag, " completion seen"}, 32'(done), 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 busy",  32'(busy), 0);
        chk("R1 done",  32'(done), 0);
        chk("R1 req",   32'(mem_req), 0);
        chk("R1 cs",    32'(new_cs), 0);
        chk("R1 ip",    32'(new_ip), 0);
        chk("R1 flags", 32'(new_flags), 0);
        chk("R1 sp",    32'(new_sp), 0);
    endtask

    task automatic t_entry_basic();
        ack_delay = 0; n_log = 0;
        mem[32'h84] = 16'hAAAA; mem[32'h86] = 16'hBBBB;
        set_core(16'h1234, 16'h5678, 16'h0302, 16'h2000, 16'h0100);
        fire_irq(8'h21);
        wait_done("R2 basic");
        chk("R8 busy low at done", 32'(busy), 0);
        chk("R2 access count", n_log, 5);
        chk_log("R2 push flags", 0, 20'h200FE, 1'b1, 16'h0302);
        chk_log("R2 push cs",    1, 20'h200FC, 1'b1, 16'h1234);
        chk_log("R2 push ip",    2, 20'h200FA, 1'b1, 16'h5678);
        chk_log("R5 reset base ip read", 3, 20'h00084, 1'b0, 16'hAAAA);
        chk_log("R4 cs read",    4, 20'h00086, 1'b0, 16'hBBBB);
        chk("R4 new ip", 32'(new_ip), 32'hAAAA);
        chk("R4 new cs", 32'(new_cs), 32'hBBBB);
        chk("R3 flags cleared", 32'(new_flags), 32'h0002);
        chk("R2 new sp", 32'(new_sp), 32'h00FA);
        @(negedge clk);
        chk("R8 done one cycle", 32'(done), 0);
    endtask

    task automatic t_entry_base();
        @(negedge clk);
        tbase_we = 1'b1; tbase_wdata = 20'h30000;
        @(negedge clk);
        tbase_we = 1'b0;
        ack_delay = 3; n_log = 0;
        mem[32'h303FC] = 16'h1111; mem[32'h303FE] = 16'h2222;
        set_core(16'h0F00, 16'h0042, 16'hFFFF, 16'h0500, 16'h0800);
        fire_irq(8'hFF);
        wait_done("R5 base");
        chk("R7 single access each", n_log, 5);
        chk("R7 request cycles", req_cycles >= 19 ? 1 : 0, 1);
        chk_log("R3 pushed original flags", 0, 20'h057FE, 1'b1, 16'hFFFF);
        chk_log("R5 top vector ip", 3, 20'h303FC, 1'b0, 16'h1111);
        chk_log("R5 top vector cs", 4, 20'h303FE, 1'b0, 16'h2222);
        chk("R3 only bits 9 and 8 cleared", 32'(new_flags), 32'hFCFF);
        chk("R4 ip from base", 32'(new_ip), 32'h1111);
        chk("R4 cs from base", 32'(new_cs), 32'h2222);
        chk("R2 sp", 32'(new_sp), 32'h07FA);
    endtask

    task automatic t_sp_wrap();
        ack_delay = 1; n_log = 0;
        mem[32'h30008] = 16'h3333; mem[32'h3000A] = 16'h4444;
        set_core(16'hCAFE, 16'hBEEF, 16'h0200, 16'h1000, 16'h0000);
        fire_irq(8'h02);
        wait_done("R10 wrap");
        chk_log("R10 flags at FFFE", 0, 20'h1FFFE, 1'b1, 16'h0200);
        chk_log("R10 cs at FFFC",    1, 20'h1FFFC, 1'b1, 16'hCAFE);
        chk_log("R10 ip at FFFA",    2, 20'h1FFFA, 1'b1, 16'hBEEF);
        chk("R10 sp wrapped", 32'(new_sp), 32'hFFFA);
        chk("R3 if cleared", 32'(new_flags), 32'h0000);
    endtask

    task automatic t_iret();
        ack_delay = 0; n_log = 0;
        set_core(16'h4444, 16'h3333, 16'h0000, 16'h1000, 16'hFFFA);
        fire_iret();
        wait_done("R6 return");
        chk("R6 access count", n_log, 3);
        chk_log("R6 pop ip",    0, 20'h1FFFA, 1'b0, 16'hBEEF);
        chk_log("R6 pop cs",    1, 20'h1FFFC, 1'b0, 16'hCAFE);
        chk_log("R6 pop flags", 2, 20'h1FFFE, 1'b0, 16'h0200);
        chk("R6 ip", 32'(new_ip), 32'hBEEF);
        chk("R6 cs", 32'(new_cs), 32'hCAFE);
        chk("R6 flags", 32'(new_flags), 32'h0200);
        chk("R10 sp wraps up to 0", 32'(new_sp), 32'h0000);
    endtask

    task automatic t_held();
        ack_delay = 2; n_log = 0;
        mem[32'h30040] = 16'h5555; mem[32'h30042] = 16'h6666;
        mem[32'h30044] = 16'h7777; mem[32'h30046] = 16'h8888;
        set_core(16'h0100, 16'h0200, 16'h0300, 16'h0500, 16'h0800);
        fire_irq(8'h10);
        repeat (2) @(negedge clk);
        chk("R8 busy during entry", 32'(busy), 1);
        fire_irq(8'h11);
        irq_vec = 8'h99;
        wait_done("R9 first");
        chk("R9 first ip", 32'(new_ip), 32'h5555);
        chk("R9 first cs", 32'(new_cs), 32'h6666);
        n_log = 0;
        @(negedge clk);
        chk("R9 second starts", 32'(busy), 1);
        wait_done("R9 second");
        chk_log("R9 held vector ip", 3, 20'h30044, 1'b0, 16'h7777);
        chk("R9 second ip", 32'(new_ip), 32'h7777);
        chk("R9 second cs", 32'(new_cs), 32'h8888);
        @(negedge clk);
        chk("R9 nothing further", 32'(busy), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_entry_basic();
        t_entry_base();
        t_sp_wrap();
        t_iret();
        t_held();
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule